// File: doc/BRIEF.md
# Link Rate Switch Controller

This block sequences a speed change on a two-rate serial link (2.5 Gbps low rate, 5 Gbps high rate). The shared PLL always runs at the high rate. The transmit serial clock is therefore chosen by a single select: either the main divider output passes straight through, or it goes through an extra divide-by-two. The block drives that select directly.

The receive side changes its own rate inside its recovery logic. The block therefore raises a separate receive change request that carries the target rate. It then waits for a completion acknowledge from the transmit path and from the receive path. These acknowledges may come in either order or together. Once both have been seen, the block pulses a done status for exactly one cycle and updates its current-rate status.

A request that arrives while a switch is running is held until that switch completes. A programmable limit flags a timeout if the acknowledges take too long to arrive.

Top module: `link_rate_switch`

## Requirements
- R1: After reset, cur_rate, tx_bypass, rx_rate, rx_chg_req, sw_busy, sw_done and tmo_err are all 0 (low rate, no switch pending).
- R2: When idle and rate_req differs from cur_rate at a clock edge, that edge sets sw_busy and rx_chg_req to 1 and sets tx_bypass and rx_rate to the requested rate. tx_bypass 1 means the undivided main divider output (5 Gbps); tx_bypass 0 means divide-by-two (2.5 Gbps).
- R3: While idle, a rate_req equal to cur_rate leaves all outputs unchanged and produces no sw_done.
- R4: During a switch, tx_ack and rx_ack are latched independently. The switch completes at the first edge at which both have been seen, whether they arrive in either order or in the same cycle.
- R5: At completion, sw_done is 1 for exactly one cycle. In the same cycle sw_busy and rx_chg_req are 0 and cur_rate equals the target rate. Each switch gives exactly one sw_done.
- R6: tx_ack and rx_ack pulses received while idle have no effect. A later switch still needs fresh acknowledges from both paths.
- R7: A change of rate_req during a switch does not alter the switch in progress. If rate_req still differs from cur_rate in the sw_done cycle, a new switch starts at the next edge.
- R8: With tmo_limit nonzero, tmo_err is set at the tmo_limit-th edge after a switch starts at which the switch has not completed. A value of 0 disables the timeout. tmo_err stays set until the next switch starts.
- R9: cur_rate reports the settled rate: 0 for a 250 MHz parallel clock (low rate), 1 for 500 MHz (high rate). It changes only in the sw_done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_req | input | 1 | Requested rate: 0 low, 1 high |
| tmo_limit | input | TMO_W | Timeout limit in cycles; 0 disables |
| tx_ack | input | 1 | Transmit path completion acknowledge |
| rx_ack | input | 1 | Receive path completion acknowledge |
| tx_bypass | output | 1 | Transmit clock select: 1 undivided, 0 divide-by-two |
| rx_chg_req | output | 1 | Receive rate change request, high during a switch |
| rx_rate | output | 1 | Target rate for the receive path |
| sw_done | output | 1 | One-cycle switch-complete pulse |
| sw_busy | output | 1 | Switch in progress |
| cur_rate | output | 1 | Settled rate status: 0 250 MHz, 1 500 MHz |
| tmo_err | output | 1 | Timeout flag |

## Verification
The assertions assume that rate_req, tx_ack and rx_ack are synchronous to clk and settle before each edge. They also assume tmo_limit is held steady during a switch. They place no limit on how acknowledges are ordered or repeated. The bench drives every input on the falling edge and changes tmo_limit only while no switch is running. It issues acknowledges as single-cycle pulses at chosen offsets: in either order, together, while idle, and withheld past the limit.

// File: rtl/link_rate_switch.sv
module link_rate_switch #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_req,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tx_ack,
  input  logic             rx_ack,
  output logic             tx_bypass,
  output logic             rx_chg_req,
  output logic             rx_rate,
  output logic             sw_done,
  output logic             sw_busy,
  output logic             cur_rate,
  output logic             tmo_err
);

  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic             tgt;
  logic             tx_seen, rx_seen;
  logic [TMO_W-1:0] cnt;

  wire tx_ok  = tx_seen | tx_ack;
  wire rx_ok  = rx_seen | rx_ack;
  wire finish = sw_busy & tx_ok & rx_ok;
  wire start  = ~sw_busy & (rate_req ^ cur_rate);

  wire [TMO_W:0] cnt_nx = {1'b0, cnt} + 1'b1;
  wire expire = sw_busy & ~finish & (tmo_limit != '0) &
                (cnt_nx == {1'b0, tmo_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_busy  <= 1'b0;
      sw_done  <= 1'b0;
      cur_rate <= 1'b0;
      tgt      <= 1'b0;
      tx_seen  <= 1'b0;
      rx_seen  <= 1'b0;
      cnt      <= '0;
      tmo_err  <= 1'b0;
    end else begin
      sw_done <= finish;
      if (start) begin
        sw_busy <= 1'b1;
        tgt     <= rate_req;
        tx_seen <= 1'b0;
        rx_seen <= 1'b0;
        cnt     <= '0;
        tmo_err <= 1'b0;
      end else if (finish) begin
        sw_busy  <= 1'b0;
        cur_rate <= tgt;
      end else if (sw_busy) begin
        tx_seen <= tx_ok;
        rx_seen <= rx_ok;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (expire) tmo_err <= 1'b1;
      end
    end
  end

  assign tx_bypass  = tgt;
  assign rx_rate    = tgt;
  assign rx_chg_req = sw_busy;

endmodule

// File: rtl/link_rate_switch_chk.sv
module link_rate_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic rate_req,
  input logic tx_bypass,
  input logic rx_chg_req,
  input logic rx_rate,
  input logic sw_done,
  input logic sw_busy,
  input logic cur_rate,
  input logic tmo_err
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_busy && rate_req != cur_rate) |=>
      (sw_busy && rx_chg_req && tx_bypass == $past(rate_req) && rx_rate == $past(rate_req)));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_busy && rate_req == cur_rate) |=> (!sw_busy && !sw_done && $stable(cur_rate)));

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> ($past(sw_busy) && !sw_busy));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |=> !sw_done);

  p_done_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> (cur_rate == rx_rate && !rx_chg_req));

  p_err_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> (sw_busy && !sw_done));

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_busy) |-> !tmo_err);

  p_rate_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_done |-> (cur_rate == $past(cur_rate)));

endmodule

bind link_rate_switch link_rate_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .tx_bypass(tx_bypass),
  .rx_chg_req(rx_chg_req), .rx_rate(rx_rate), .sw_done(sw_done),
  .sw_busy(sw_busy), .cur_rate(cur_rate), .tmo_err(tmo_err)
);

// File: tb/sim_link_rate_switch.sv
`timescale 1ns/1ps
module sim_link_rate_switch;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_req = 1'b0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic tx_ack = 1'b0, rx_ack = 1'b0;
  logic tx_bypass, rx_chg_req, rx_rate, sw_done, sw_busy, cur_rate, tmo_err;

  int n_tests = 0, n_fail = 0, cyc = 0, done_cnt = 0;

  always #10 clk = ~clk;

  link_rate_switch #(.TMO_W(TMO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .tmo_limit(tmo_limit),
    .tx_ack(tx_ack), .rx_ack(rx_ack), .tx_bypass(tx_bypass), .rx_chg_req(rx_chg_req),
    .rx_rate(rx_rate), .sw_done(sw_done), .sw_busy(sw_busy), .cur_rate(cur_rate),
    .tmo_err(tmo_err)
  );

  // behavioural reference
  int m_cur = 0, m_busy = 0, m_tgt = 0, m_txs = 0, m_rxs = 0, m_cnt = 0, m_err = 0, m_done = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cur = 0; m_busy = 0; m_tgt = 0; m_txs = 0; m_rxs = 0; m_cnt = 0; m_err = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if ((m_txs != 0 || tx_ack) && (m_rxs != 0 || rx_ack)) begin
          m_busy = 0; m_cur = m_tgt; m_done = 1;
        end else begin
          if (tx_ack) m_txs = 1;
          if (rx_ack) m_rxs = 1;
          if (tmo_limit != 0 && m_cnt + 1 == int'(tmo_limit)) m_err = 1;
          m_cnt++;
        end
      end else if (int'(rate_req) != m_cur) begin
        m_busy = 1; m_tgt = int'(rate_req); m_txs = 0; m_rxs = 0; m_cnt = 0; m_err = 0;
      end
    end
  end

  task automatic check(input string req, input string nm, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, nm, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R2", "sw_busy", int'(sw_busy), m_busy);
      check("R2", "rx_chg_req", int'(rx_chg_req), m_busy);
      check("R2", "tx_bypass", int'(tx_bypass), m_tgt);
      check("R2", "rx_rate", int'(rx_rate), m_tgt);
      check("R5", "sw_done", int'(sw_done), m_done);
      check("R9", "cur_rate", int'(cur_rate), m_cur);
      check("R8", "tmo_err", int'(tmo_err), m_err);
      if (sw_done) done_cnt++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_ack = 1'b0; rx_ack = 1'b0;
    end
  endtask

  // pulses acknowledges at given offsets (negative = never)
  task automatic acks(input int tdel, input int rdel, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tx_ack = (i == tdel);
      rx_ack = (i == rdel);
    end
    @(negedge clk);
    tx_ack = 1'b0; rx_ack = 1'b0;
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cur_rate", int'(cur_rate), 0);
    check("R1", "tx_bypass", int'(tx_bypass), 0);
    check("R1", "rx_rate", int'(rx_rate), 0);
    check("R1", "rx_chg_req", int'(rx_chg_req), 0);
    check("R1", "sw_busy", int'(sw_busy), 0);
    check("R1", "sw_done", int'(sw_done), 0);
    check("R1", "tmo_err", int'(tmo_err), 0);
    rst_n = 1'b1;
    idle(2);

    // R3 request equal to current rate
    d0 = done_cnt;
    idle(10);
    check("R3", "done pulses", done_cnt - d0, 0);
    check("R3", "sw_busy", int'(sw_busy), 0);

    // R2/R4 switch up, tx first
    d0 = done_cnt;
    rate_req = 1'b1;
    @(negedge clk);
    check("R2", "tx_bypass after start", int'(tx_bypass), 1);
    check("R2", "rx_chg_req after start", int'(rx_chg_req), 1);
    acks(2, 5, 8);
    idle(2);
    check("R4", "done pulses tx first", done_cnt - d0, 1);
    check("R9", "cur_rate high", int'(cur_rate), 1);

    // R4 switch down, rx first
    d0 = done_cnt;
    rate_req = 1'b0;
    acks(4, 1, 7);
    idle(2);
    check("R4", "done pulses rx first", done_cnt - d0, 1);
    check("R9", "cur_rate low", int'(cur_rate), 0);

    // R4 both same cycle
    d0 = done_cnt;
    rate_req = 1'b1;
    acks(3, 3, 6);
    idle(2);
    check("R4", "done pulses same cycle", done_cnt - d0, 1);

    // R6 idle acknowledges ignored, then a switch needs both fresh
    d0 = done_cnt;
    acks(0, 1, 3);
    check("R6", "idle ack done pulses", done_cnt - d0, 0);
    rate_req = 1'b0;
    acks(-1, 2, 6);
    check("R6", "no done without tx ack", done_cnt - d0, 0);
    check("R6", "still busy", int'(sw_busy), 1);
    acks(1, -1, 3);
    idle(2);
    check("R6", "done after tx ack", done_cnt - d0, 1);

    // R7 request toggles during a switch
    d0 = done_cnt;
    rate_req = 1'b1;
    @(negedge clk);
    rate_req = 1'b0;
    acks(2, 3, 5);
    idle(1);
    check("R7", "second switch started", int'(sw_busy), 1);
    check("R7", "second target low", int'(tx_bypass), 0);
    acks(1, 1, 3);
    idle(2);
    check("R7", "two done pulses", done_cnt - d0, 2);
    check("R7", "final rate low", int'(cur_rate), 0);

    // R8 timeout with limit 4
    tmo_limit = 16'd4;
    rate_req = 1'b1;
    acks(-1, -1, 8);
    check("R8", "tmo_err set", int'(tmo_err), 1);
    acks(0, 0, 2);
    idle(2);
    check("R9", "rate after late acks", int'(cur_rate), 1);
    rate_req = 1'b0;
    idle(1);
    check("R8", "tmo_err cleared at start", int'(tmo_err), 0);
    acks(1, 2, 4);
    idle(2);

    // R8 limit 0 disables
    tmo_limit = '0;
    rate_req = 1'b1;
    acks(-1, -1, 30);
    check("R8", "no err when disabled", int'(tmo_err), 0);
    acks(0, 0, 2);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule